// File: doc/BRIEF.md
# Modulo 2^p-1 End-Around-Carry Adder

This block adds two residues modulo a Mersenne-form modulus M = 2^p-1. The exponent p is a runtime input, and the operand datapath is 16 bits wide. The logic is purely combinational. It has no clock, no reset and no stored state, so the result follows the inputs within the same cycle.

The modular reduction uses the end-around carry. Two ripple adders run side by side: one computes a+b and the other computes a+b+1. The carry leaving bit p-1 of the first adder chooses between them. A carry there means the sum reached 2^p, and wrapping that carry back into bit 0 is the same as subtracting M.

After the selection, all bits from p upward are cleared. A selected value equal to the p-bit all-ones pattern is replaced by zero, so the output is always the canonical residue in the range 0..M-1. A modular squaring datapath can chain this adder to accumulate partial products without a separate reduction step.

Top module: `mea_add`

## Requirements
- R1: For 2 <= p <= 16, `sum_o` equals (opa + opb) mod (2^p-1), where each operand is first reduced as described in R5 and R6.
- R2: Every bit of `sum_o` at position p or above is 0.
- R3: `sum_o` never equals 2^p-1. A pair whose sum is exactly 2^p-1 gives 0; for example, p=7, 100+27 gives 0.
- R4: When the sum reaches 2^p or more, the carry out of bit p-1 is added back at bit 0. For example, p=7, 100+50 gives 23, and p=16, 65534+65534 gives 65533.
- R5: Operand bits at position p and above have no effect on `sum_o`.
- R6: An operand whose low p bits are all ones acts as zero. For example, p=5, 31+9 gives 9.
- R7: A `p_sel` value below 2 behaves as p=2, and a value above 16 behaves as p=16.
- R8: `sum_o` depends only on the present inputs. A new input set gives its result within the same clock period, whatever the previous inputs were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand; only bits below p are used |
| opb | input | 16 | Second operand; only bits below p are used |
| p_sel | input | 5 | Exponent p of the modulus 2^p-1 (clamped to 2..16) |
| sum_o | output | 16 | Canonical residue of opa+opb, zero above bit p-1 |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the inputs and `sum_o`. The driver changes the operands and p on a falling clock edge and queues the expected residue at the same moment. The monitor takes that item off the queue one nanosecond after the next rising edge and compares it with `sum_o`. This gives the adder half a period to settle and keeps every sample clear of both clock edges.

Consecutive vectors use unrelated operands and exponents, which exercises R8. A stale result from an earlier vector would show up as a miscompare.

// File: rtl/mea_pkg.sv
package mea_pkg;
    localparam int unsigned MEA_W  = 16;
    localparam int unsigned MEA_PW = $clog2(MEA_W + 1);
    localparam int unsigned MEA_PMIN = 2;
endpackage

// File: rtl/mea_mask_gen.sv
module mea_mask_gen #(
    parameter int unsigned W  = 16,
    parameter int unsigned PW = 5,
    parameter int unsigned PMIN = 2
) (
    input  logic [PW-1:0] p_raw,
    output logic [PW-1:0] p_eff,
    output logic [W-1:0]  mask
);
    // Clamp the exponent into the supported range.
    always_comb begin
        if (p_raw < PW'(PMIN))
            p_eff = PW'(PMIN);
        else if (p_raw > PW'(W))
            p_eff = PW'(W);
        else
            p_eff = p_raw;
    end

    // Thermometer mask: bit i is set while i < p.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (p_eff > PW'(i));
    end
endmodule

// File: rtl/mea_dual_sum.sv
module mea_dual_sum #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] xa,
    input  logic [W-1:0] xb,
    output logic [W-1:0] sum_c0,
    output logic [W-1:0] sum_c1,
    output logic [W:0]   carry_c0
);
    logic [W-1:0] prop;
    logic [W-1:0] gen;
    logic [W-1:0] carry_c1;

    assign prop = xa ^ xb;
    assign gen  = xa & xb;

    assign carry_c0[0] = 1'b0;
    assign carry_c1[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_c0[i]     = prop[i] ^ carry_c0[i];
        assign sum_c1[i]     = prop[i] ^ carry_c1[i];
        assign carry_c0[i+1] = gen[i] | (prop[i] & carry_c0[i]);
        if (i < W - 1) begin : g_c1
            assign carry_c1[i+1] = gen[i] | (prop[i] & carry_c1[i]);
        end
    end
endmodule

// File: rtl/mea_carry_tap.sv
module mea_carry_tap #(
    parameter int unsigned W  = 16,
    parameter int unsigned PW = 5
) (
    input  logic [W:0]    carries,
    input  logic [PW-1:0] p_eff,
    output logic          wrap
);
    // The carry into bit p is the carry out of bit p-1.
    assign wrap = carries[p_eff];
endmodule

// File: rtl/mea_add.sv
module mea_add
    import mea_pkg::*;
#(
    parameter int unsigned W  = MEA_W,
    parameter int unsigned PW = $clog2(W + 1)
) (
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [PW-1:0] p_sel,
    output logic [W-1:0]  sum_o
);
    logic [PW-1:0] p_eff;
    logic [W-1:0]  mask;
    logic [W-1:0]  xa, xb;
    logic [W-1:0]  s_c0, s_c1;
    logic [W:0]    c_c0;
    logic          wrap;
    logic [W-1:0]  picked;

    mea_mask_gen #(.W(W), .PW(PW), .PMIN(MEA_PMIN)) u_mask (
        .p_raw (p_sel),
        .p_eff (p_eff),
        .mask  (mask)
    );

    assign xa = opa & mask;
    assign xb = opb & mask;

    mea_dual_sum #(.W(W)) u_sums (
        .xa       (xa),
        .xb       (xb),
        .sum_c0   (s_c0),
        .sum_c1   (s_c1),
        .carry_c0 (c_c0)
    );

    mea_carry_tap #(.W(W), .PW(PW)) u_tap (
        .carries (c_c0),
        .p_eff   (p_eff),
        .wrap    (wrap)
    );

    // Pick the sum with the wrapped carry, then canonicalize.
    always_comb begin
        picked = (wrap ? s_c1 : s_c0) & mask;
        if (picked == mask)
            sum_o = '0;
        else
            sum_o = picked;
    end
endmodule

// File: rtl/mea_add_chk.sv
module mea_add_chk #(
    parameter int unsigned W  = 16,
    parameter int unsigned PW = 5
) (
    input logic [W-1:0]  opa,
    input logic [W-1:0]  opb,
    input logic [PW-1:0] p_sel,
    input logic [W-1:0]  sum_o
);
    int unsigned pe;
    logic [31:0] modv, ra, rb, expv, outv;

    always_comb begin
        if (int'(p_sel) < 2)
            pe = 2;
        else if (int'(p_sel) > int'(W))
            pe = W;
        else
            pe = int'(p_sel);
        modv = (32'd1 << pe) - 32'd1;
        ra   = (32'(opa) & modv) % modv;
        rb   = (32'(opb) & modv) % modv;
        expv = (ra + rb) % modv;
        outv = 32'(sum_o);
    end

    always_comb begin
        p_residue_r1: assert (outv == expv)
            else $error("R1 residue mismatch");
        p_high_clear_r2: assert ((outv & ~modv) == 32'd0)
            else $error("R2 bits above p set");
        p_canonical_r3: assert (outv != modv)
            else $error("R3 non-canonical all-ones");
        p_wrap_r4: assert (!((ra + rb) >= modv + 32'd1) || (outv == ra + rb - modv))
            else $error("R4 end-around carry not applied");
    end
endmodule

bind mea_add mea_add_chk #(.W(W), .PW(PW)) u_chk (
    .opa   (opa),
    .opb   (opb),
    .p_sel (p_sel),
    .sum_o (sum_o)
);

// File: tb/sim_mea_add.sv
module sim_mea_add;
    localparam int W  = 16;
    localparam int PW = 5;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        int           p;
        int           expv;
        string        req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [PW-1:0] p_sel = '0;
    logic [W-1:0]  sum_o;

    item_t exp_q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    drv_done = 1'b0;

    always #5 clk = ~clk;

    mea_add u0 (
        .opa   (opa),
        .opb   (opb),
        .p_sel (p_sel),
        .sum_o (sum_o)
    );

    function automatic int ref_mod(int a, int b, int p);
        int pe, m;
        pe = (p < 2) ? 2 : ((p > W) ? W : p);
        m  = (1 << pe) - 1;
        return (((a & m) % m) + ((b & m) % m)) % m;
    endfunction

    task automatic drive(input int a, input int b, input int p, input string req);
        item_t it;
        @(negedge clk);
        opa   = W'(a);
        opb   = W'(b);
        p_sel = PW'(p);
        it.a = W'(a); it.b = W'(b); it.p = p;
        it.expv = ref_mod(a, b, p);
        it.req  = req;
        exp_q.push_back(it);
    endtask

    // Monitor: compare each queued item after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_vec++;
                if (int'(sum_o) != it.expv) begin
                    n_fail++;
                    $display("FAIL %s p=%0d a=%0d b=%0d actual=%0d expected=%0d",
                             it.req, it.p, it.a, it.b, sum_o, it.expv);
                end
            end
        end
    end

    // Driver
    initial begin
        // Reset-time check: zero operands give zero.
        drive(0, 0, 0, "R8_reset");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // Worked examples
        drive(100, 27, 7, "R3");
        drive(100, 50, 7, "R4");
        drive(65534, 65534, 16, "R4");
        drive(31, 9, 5, "R6");
        drive(16'hFF80 | 100, 16'hC000 | 50, 7, "R5");
        drive(3, 2, 0, "R7");
        drive(3, 2, 1, "R7");
        drive(40000, 30000, 31, "R7");
        drive(65535, 65535, 17, "R7");
        // All exponents: corners and random operands.
        for (int p = 2; p <= W; p++) begin
            int m;
            m = (1 << p) - 1;
            drive(0, 0, p, "R1");
            drive(m - 1, 1, p, "R3");
            drive(m - 1, m - 1, p, "R4");
            drive(m, m, p, "R6");
            drive(m, 1, p, "R6");
            drive(1 << (p - 1), 1 << (p - 1), p, "R4");
            for (int k = 0; k < 24; k++)
                drive(int'($urandom_range(0, m - 1)), int'($urandom_range(0, m - 1)), p, "R1");
            for (int k = 0; k < 12; k++)
                drive(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), p, "R2");
            for (int k = 0; k < 8; k++)
                drive(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                      int'($urandom_range(2, W)), "R8");
        end
        @(negedge clk);
        drv_done = 1'b1;
    end

    // Completion and watchdog
    initial begin
        int cyc;
        cyc = 0;
        while (!(drv_done && exp_q.size() == 0) && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
        end
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule